// File: doc/BRIEF.md
# Programmable Sum-of-Products Macrocell

This block is one output cell of an erasable programmable logic device. A small AND array forms product terms from a vector of array inputs. Each term can pick any input in true form, in complemented form, or leave it out. Eight of these terms are ORed into a sum. The sum can be inverted, and then either drives the pin directly or feeds a flip-flop whose value drives the pin.

Three more product terms have their own jobs. One clears the flip-flop asynchronously. One can clock the flip-flop in place of the global clock. One drives the enable of the pin's tri-state driver.

The flip-flop works as a D or a T type, on either clock edge. A feedback signal returns to the array. It carries either the flip-flop state or the level sensed at the pad. All configuration inputs are static programming bits. They are changed only while `rst_ni` is low.

Top module: `pld_macrocell`

## Requirements
- R1: For term k and input i, `pt_true_i[k][i]`=1 puts input i into the AND, and `pt_comp_i[k][i]`=1 puts its complement into the AND. A term with no bit set in either mask evaluates to 1. A term with both bits set for the same input evaluates to 0.
- R2: The sum is the OR of terms 0 to 7.
- R3: With `invert_i`=1 the sum is inverted before it reaches the output path or the flip-flop.
- R4: With `reg_en_i`=0, `pin_o` follows the polarity-adjusted sum combinationally, with no clock.
- R5: With `reg_en_i`=1 and `tff_i`=0, the flip-flop loads the polarity-adjusted sum on the active clock edge. It holds its value between edges, and `pin_o` shows it.
- R6: With `tff_i`=1, the flip-flop inverts its state on an active edge when the polarity-adjusted sum is 1, and holds it when the sum is 0.
- R7: With `fall_edge_i`=1 the flip-flop triggers on the falling edge of its clock source, and rising edges have no effect.
- R8: With `local_clk_i`=1 the flip-flop is clocked by term 9 (the clock term), and `clk_i` has no effect on it.
- R9: Term 8 (the clear term) and a low `rst_ni` each clear the flip-flop to 0 at once, without a clock edge. Clear wins over any clock edge while it is active.
- R10: Term 10 (the enable term) drives `pin_oe_o`, where 0 means the pad is high-impedance. While the pad is disabled, register feedback still shows the flip-flop state.
- R11: With `fb_pin_i`=1, `fb_o` carries the pad level `pin_i`. With `fb_pin_i`=0, `fb_o` carries the flip-flop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the flip-flop |
| in_i | input | N_IN | Array inputs |
| pt_true_i | input | N_TERMS x N_IN | True-form select mask for each term |
| pt_comp_i | input | N_TERMS x N_IN | Complement-form select mask for each term |
| invert_i | input | 1 | Output polarity: 1 inverts the sum |
| reg_en_i | input | 1 | 1 selects registered output, 0 selects combinational output |
| tff_i | input | 1 | 1 selects T behaviour, 0 selects D behaviour |
| fall_edge_i | input | 1 | 1 selects falling-edge triggering |
| local_clk_i | input | 1 | 1 clocks the flip-flop from term 9 |
| fb_pin_i | input | 1 | 1 takes feedback from the pad, 0 from the register |
| pin_i | input | 1 | Level sensed at the pad |
| pin_o | output | 1 | Data to the pad driver |
| pin_oe_o | output | 1 | Pad driver enable, 0 means high-impedance |
| fb_o | output | 1 | Feedback to the array |

## Verification
A table of input vectors runs the combinational path. It fires each of the two live terms alone and both together. It also presents inputs where one literal of a term is right and the other is wrong, and repeats several vectors with inversion on. Together these separate an AND from an OR, a true literal from a complemented one, and an applied polarity from an ignored one. Empty and contradictory terms are then checked against each other on the same inputs.

The registered modes are tried with the same data pattern under D, T, falling-edge and term-clock settings. The output is sampled just before and just after each candidate edge, so an edge of the wrong polarity or source shows up as an early or missing change. Clear is raised between edges and held across one. This separates an asynchronous clear from a synchronous one, and shows that clear wins over the edge.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  // control terms follow the sum terms, in this order
  localparam int unsigned CT_CLR     = 0;
  localparam int unsigned CT_CLK     = 1;
  localparam int unsigned CT_OE      = 2;
  localparam int unsigned CTRL_TERMS = 3;
endpackage

// File: rtl/pld_mc_pterm.sv
module pld_mc_pterm #(
  parameter int unsigned N_IN = 8
) (
  input  logic [N_IN-1:0] in_i,
  input  logic [N_IN-1:0] use_true_i,
  input  logic [N_IN-1:0] use_comp_i,
  output logic            term_o
);
  // unused literals contribute 1; both polarities force 0
  always_comb term_o = &((in_i | ~use_true_i) & (~in_i | ~use_comp_i));
endmodule

// File: rtl/pld_mc_array.sv
module pld_mc_array #(
  parameter int unsigned N_IN    = 8,
  parameter int unsigned N_SUM   = 8,
  localparam int unsigned N_TERMS = N_SUM + pld_mc_pkg::CTRL_TERMS
) (
  input  logic [N_IN-1:0]               in_i,
  input  logic [N_TERMS-1:0][N_IN-1:0]  pt_true_i,
  input  logic [N_TERMS-1:0][N_IN-1:0]  pt_comp_i,
  output logic [N_TERMS-1:0]            terms_o,
  output logic                          sum_o
);
  for (genvar k = 0; k < N_TERMS; k++) begin : g_term
    pld_mc_pterm #(.N_IN(N_IN)) pterm_i (
      .in_i      (in_i),
      .use_true_i(pt_true_i[k]),
      .use_comp_i(pt_comp_i[k]),
      .term_o    (terms_o[k])
    );
  end

  always_comb sum_o = |terms_o[N_SUM-1:0];
endmodule

// File: rtl/pld_mc_ff.sv
module pld_mc_ff (
  input  logic gclk_i,
  input  logic lclk_i,
  input  logic lsel_i,
  input  logic fall_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tff_i,
  input  logic d_i,
  output logic q_o
);
  logic src_clk, eff_clk, clr_any;

  assign src_clk = lsel_i ? lclk_i : gclk_i;
  assign eff_clk = src_clk ^ fall_i;
  assign clr_any = clr_i | ~rst_ni;

  always_ff @(posedge eff_clk or posedge clr_any) begin
    if (clr_any)    q_o <= 1'b0;
    else if (tff_i) q_o <= q_o ^ d_i;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
  parameter int unsigned N_IN    = 8,
  parameter int unsigned N_SUM   = 8,
  localparam int unsigned N_TERMS = N_SUM + pld_mc_pkg::CTRL_TERMS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_IN-1:0]              in_i,
  input  logic [N_TERMS-1:0][N_IN-1:0] pt_true_i,
  input  logic [N_TERMS-1:0][N_IN-1:0] pt_comp_i,
  input  logic                         invert_i,
  input  logic                         reg_en_i,
  input  logic                         tff_i,
  input  logic                         fall_edge_i,
  input  logic                         local_clk_i,
  input  logic                         fb_pin_i,
  input  logic                         pin_i,
  output logic                         pin_o,
  output logic                         pin_oe_o,
  output logic                         fb_o
);
  import pld_mc_pkg::*;

  localparam int unsigned IDX_CLR = N_SUM + CT_CLR;
  localparam int unsigned IDX_CLK = N_SUM + CT_CLK;
  localparam int unsigned IDX_OE  = N_SUM + CT_OE;

  logic [N_TERMS-1:0] terms;
  logic sum_raw, sum_pol, clr_term, clk_term, q;

  pld_mc_array #(.N_IN(N_IN), .N_SUM(N_SUM)) array_i (
    .in_i     (in_i),
    .pt_true_i(pt_true_i),
    .pt_comp_i(pt_comp_i),
    .terms_o  (terms),
    .sum_o    (sum_raw)
  );

  assign sum_pol  = sum_raw ^ invert_i;
  assign clr_term = terms[IDX_CLR];
  assign clk_term = terms[IDX_CLK];

  pld_mc_ff ff_i (
    .gclk_i(clk_i),
    .lclk_i(clk_term),
    .lsel_i(local_clk_i),
    .fall_i(fall_edge_i),
    .rst_ni(rst_ni),
    .clr_i (clr_term),
    .tff_i (tff_i),
    .d_i   (sum_pol),
    .q_o   (q)
  );

  assign pin_o    = reg_en_i ? q : sum_pol;
  assign pin_oe_o = terms[IDX_OE];
  assign fb_o     = fb_pin_i ? pin_i : q;
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk #(
  parameter int unsigned N_IN = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_IN-1:0] true0,
  input logic [N_IN-1:0] comp0,
  input logic            term0,
  input logic            sum_raw,
  input logic            clr_term,
  input logic            q,
  input logic            invert_i,
  input logic            reg_en_i,
  input logic            tff_i,
  input logic            fall_edge_i,
  input logic            local_clk_i,
  input logic            fb_pin_i,
  input logic            pin_o,
  input logic            fb_o
);
  assert_empty_term_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (true0 == '0 && comp0 == '0) |-> term0);

  assert_void_term_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(true0 & comp0)) |-> !term0);

  assert_comb_path_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_en_i |-> (pin_o == (sum_raw ^ invert_i)));

  assert_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_i && tff_i && !local_clk_i && !fall_edge_i && !clr_term && (sum_raw ^ invert_i))
    |=> (clr_term || q != $past(q)));

  assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_term |-> !q);

  assert_reg_feedback_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_i && !fb_pin_i) |-> (fb_o == pin_o));
endmodule

bind pld_macrocell pld_macrocell_chk #(.N_IN(N_IN)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .true0      (pt_true_i[0]),
  .comp0      (pt_comp_i[0]),
  .term0      (terms[0]),
  .sum_raw    (sum_raw),
  .clr_term   (clr_term),
  .q          (q),
  .invert_i   (invert_i),
  .reg_en_i   (reg_en_i),
  .tff_i      (tff_i),
  .fall_edge_i(fall_edge_i),
  .local_clk_i(local_clk_i),
  .fb_pin_i   (fb_pin_i),
  .pin_o      (pin_o),
  .fb_o       (fb_o)
);

// File: tb/pld_macrocell_tb_top.sv
module pld_macrocell_tb_top;
  localparam int unsigned N_IN    = 8;
  localparam int unsigned N_SUM   = 8;
  localparam int unsigned N_TERMS = N_SUM + 3;
  localparam int NVEC = 10;
  // {expected pin, invert, inputs}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h00}, {1'b1, 1'b0, 8'h01}, {1'b0, 1'b0, 8'h03},
    {1'b1, 1'b0, 8'h0C}, {1'b1, 1'b0, 8'h0F}, {1'b0, 1'b0, 8'h04},
    {1'b0, 1'b1, 8'h01}, {1'b1, 1'b1, 8'h00}, {1'b1, 1'b1, 8'h0B},
    {1'b1, 1'b0, 8'h0D}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_IN-1:0] in_i = '0;
  logic [N_TERMS-1:0][N_IN-1:0] pt_true_i, pt_comp_i;
  logic invert_i = 0, reg_en_i = 1, tff_i = 0, fall_edge_i = 0, local_clk_i = 0;
  logic fb_pin_i = 0, pin_i = 0;
  logic pin_o, pin_oe_o, fb_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pld_macrocell #(.N_IN(N_IN), .N_SUM(N_SUM)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(in_i),
    .pt_true_i(pt_true_i), .pt_comp_i(pt_comp_i),
    .invert_i(invert_i), .reg_en_i(reg_en_i), .tff_i(tff_i),
    .fall_edge_i(fall_edge_i), .local_clk_i(local_clk_i),
    .fb_pin_i(fb_pin_i), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .fb_o(fb_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_r();
    @(posedge clk_i); #1;
  endtask

  // mode change only under reset
  task automatic cfg_reset(input logic reg_en, input logic tff, input logic fall, input logic lsel);
    edge_r();
    rst_ni = 0;
    reg_en_i = reg_en; tff_i = tff; fall_edge_i = fall; local_clk_i = lsel;
    in_i = '0;
    edge_r();
    rst_ni = 1;
  endtask

  task automatic set_base();
    pt_true_i = '0; pt_comp_i = '0;
    pt_true_i[0] = 8'h01; pt_comp_i[0] = 8'h02;       // in0 & ~in1
    pt_true_i[1] = 8'h0C;                             // in2 & in3
    for (int k = 2; k < 8; k++) begin
      pt_true_i[k] = 8'h10; pt_comp_i[k] = 8'h10;     // always 0
    end
    pt_true_i[8]  = 8'h40;                            // clear = in6
    pt_true_i[9]  = 8'h80;                            // clock = in7
    pt_comp_i[10] = 8'h20;                            // enable = ~in5
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    set_base();
    edge_r(); edge_r();
    // reset state
    check("R9 reset pin", pin_o, 1'b0);
    check("R9 reset fb", fb_o, 1'b0);
    check("R10 enable on", pin_oe_o, 1'b1);
    rst_ni = 1;

    // R2 R3 R4 combinational table
    reg_en_i = 0;
    for (int v = 0; v < NVEC; v++) begin
      in_i = VEC[v][7:0]; invert_i = VEC[v][8];
      #1;
      check("R2/R3/R4 comb vector", pin_o, VEC[v][9]);
    end
    invert_i = 0;

    // R1 empty term vs contradictory term
    in_i = 8'h00;
    pt_true_i[3] = '0; pt_comp_i[3] = '0; #1;
    check("R1 empty term", pin_o, 1'b1);
    pt_true_i[3] = 8'h01; pt_comp_i[3] = 8'h01; in_i = 8'h03; #1;
    check("R1 contradictory term", pin_o, 1'b0);
    set_base();

    // R5 D capture on rising edge
    cfg_reset(1, 0, 0, 0);
    in_i = 8'h01; #1;
    check("R5 hold before edge", pin_o, 1'b0);
    edge_r();
    check("R5 load 1", pin_o, 1'b1);
    in_i = 8'h00;
    edge_r();
    check("R5 load 0", pin_o, 1'b0);

    // R6 toggle
    cfg_reset(1, 1, 0, 0);
    in_i = 8'h01;
    edge_r(); check("R6 toggle 1", pin_o, 1'b1);
    edge_r(); check("R6 toggle 2", pin_o, 1'b0);
    edge_r(); check("R6 toggle 3", pin_o, 1'b1);
    in_i = 8'h00;
    edge_r(); check("R6 hold", pin_o, 1'b1);
    edge_r(); check("R6 hold again", pin_o, 1'b1);

    // R7 falling edge
    cfg_reset(1, 0, 1, 0);
    in_i = 8'h01; #1;
    check("R7 no change before fall", pin_o, 1'b0);
    @(negedge clk_i); #1;
    check("R7 load on fall", pin_o, 1'b1);
    in_i = 8'h00;
    edge_r();
    check("R7 rising ignored", pin_o, 1'b1);
    @(negedge clk_i); #1;
    check("R7 next fall", pin_o, 1'b0);

    // R8 term clock
    cfg_reset(1, 0, 0, 1);
    in_i = 8'h01;
    edge_r(); edge_r(); edge_r();
    check("R8 global clock ignored", pin_o, 1'b0);
    in_i = 8'h81; #1;
    check("R8 term clock rise", pin_o, 1'b1);
    in_i = 8'h80; #1;
    check("R8 data change no edge", pin_o, 1'b1);
    in_i = 8'h00; #1;
    check("R8 term clock fall no load", pin_o, 1'b1);
    in_i = 8'h80; #1;
    check("R8 second term edge", pin_o, 1'b0);

    // R9 asynchronous clear with priority
    cfg_reset(1, 0, 0, 0);
    in_i = 8'h01;
    edge_r();
    check("R9 preload", pin_o, 1'b1);
    in_i = 8'h41; #1;
    check("R9 async clear", pin_o, 1'b0);
    edge_r();
    check("R9 clear beats edge", pin_o, 1'b0);
    in_i = 8'h01; #1;
    check("R9 released waits edge", pin_o, 1'b0);
    edge_r();
    check("R9 reload", pin_o, 1'b1);

    // R10 enable term, register feedback while disabled
    in_i = 8'h21; #1;
    check("R10 driver off", pin_oe_o, 1'b0);
    check("R10 fb while off", fb_o, 1'b1);
    in_i = 8'h01; #1;
    check("R10 driver on", pin_oe_o, 1'b1);

    // R11 pad feedback
    fb_pin_i = 1; pin_i = 0; #1;
    check("R11 pad 0", fb_o, 1'b0);
    pin_i = 1; #1;
    check("R11 pad 1", fb_o, 1'b1);
    fb_pin_i = 0; pin_i = 0; #1;
    check("R11 back to reg", fb_o, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule